// File: doc/BRIEF.md
# AXI Error-Response Default Slave

This block is an AXI4 slave endpoint that answers every transaction routed to it with an error response. It is meant to sit behind an interconnect on address regions that have no real target. It stores nothing. It keeps each channel compliant with the burst rules, so a master that reaches it never hangs and never sees a short or malformed burst.

On the write side the block accepts one address, then takes in write data beats until it accepts the beat flagged last. Only after that beat does it raise one write response, carrying the captured ID. On the read side it captures the ID and the length field of the read address. It then streams length-plus-one beats of zero data, each marked with the error code, and flags only the final beat as last. The error code is fixed when the block is built.

Each channel handles one transaction at a time, and the read and write channels run independently of each other.

Top module: `axi_err_slave`

## Requirements
- R1: After reset, and after a reset applied in the middle of a burst, the block shows awready=1, arready=1, wready=0, bvalid=0 and rvalid=0.
- R2: After a write address is accepted, the block accepts data beats until it accepts the beat with wlast=1. bvalid stays 0 until that handshake has taken place, then rises exactly once for the burst. Gaps in wvalid do not change this.
- R3: bid equals the awid captured at the address handshake, and bresp carries the error code.
- R4: A read with length field L returns exactly L+1 beats. rlast=1 on the final beat only, so a burst with L=0 flags its single beat as last.
- R5: On every read beat, rid equals the captured arid, rresp carries the error code, and rdata is all zeros.
- R6: The error code is 2'b11 (decode error) by default, and 2'b10 (slave error) when the parameter USE_SLVERR is 1. The same code is used on both response channels.
- R7: While bvalid or rvalid is high and its ready is low, the valid stays high and its ID, response and last flag stay unchanged.
- R8: awready stays 0 from the write address handshake until the write response handshake. arready stays 0 from the read address handshake until the last read beat handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awid | input | ID_W | Write transaction ID |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wlast | input | 1 | Last write beat flag |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| arid | input | ID_W | Read transaction ID |
| arlen | input | LEN_W | Read burst length minus one |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | output | ID_W | Read data ID |
| rdata | output | DATA_W | Read data, always zero |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Last read beat flag |

## Verification
The bench builds two copies of the block. Both use ID_W=4, LEN_W=8 and DATA_W=32. One copy keeps the default decode-error code, and the other sets USE_SLVERR=1. Both copies receive the same stimulus, so the two response encodings are compared beat for beat on identical traffic. The 8-bit length field brings within reach both the single-beat burst and the full 256-beat burst, which exercise the beat counter at both of its ends.

// File: rtl/axerr_pkg.sv
package axerr_pkg;

  typedef logic [1:0] resp_t;

  localparam resp_t RESP_SLVERR = 2'b10;
  localparam resp_t RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {
    WR_ADDR = 2'd0,
    WR_DATA = 2'd1,
    WR_RESP = 2'd2
  } wr_state_t;

  typedef enum logic {
    RD_ADDR  = 1'b0,
    RD_BURST = 1'b1
  } rd_state_t;

  function automatic resp_t pick_code(input bit use_slverr);
    return use_slverr ? RESP_SLVERR : RESP_DECERR;
  endfunction

endpackage

// File: rtl/axerr_beat_cnt.sv
module axerr_beat_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             at_zero
);

  logic [LEN_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign at_zero = (remain_q == '0);

  // R4: a beat is consumed before the counter has finished (the last beat ends the burst instead)
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec && !at_zero |=> ($past(remain_q) - 1'b1) == remain_q);

  a_r4_load_dec_excl: assert property (@(posedge clk) disable iff (rst)
    !(load && dec));

endmodule

// File: rtl/axerr_wr_chan.sv
module axerr_wr_chan
  import axerr_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter bit USE_SLVERR = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            awvalid,
  output logic            awready,
  input  logic [ID_W-1:0] awid,
  input  logic            wvalid,
  output logic            wready,
  input  logic            wlast,
  output logic            bvalid,
  input  logic            bready,
  output logic [ID_W-1:0] bid,
  output logic [1:0]      bresp
);

  localparam resp_t ERR_CODE = pick_code(USE_SLVERR);

  wr_state_t       state_q;
  logic [ID_W-1:0] id_q;
  logic            aw_hs, w_hs, b_hs;

  assign aw_hs = awvalid && awready;
  assign w_hs  = wvalid && wready;
  assign b_hs  = bvalid && bready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WR_ADDR;
      id_q    <= '0;
    end else begin
      case (state_q)
        WR_ADDR: if (aw_hs) begin
          state_q <= WR_DATA;
          id_q    <= awid;
        end
        WR_DATA: if (w_hs && wlast) state_q <= WR_RESP;
        WR_RESP: if (b_hs) state_q <= WR_ADDR;
        default: state_q <= WR_ADDR;
      endcase
    end
  end

  assign awready = (state_q == WR_ADDR);
  assign wready  = (state_q == WR_DATA);
  assign bvalid  = (state_q == WR_RESP);
  assign bid     = id_q;
  assign bresp   = ERR_CODE;

  // R2: the response appears only right after the last data beat handshake
  a_r2_resp_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(bvalid) |-> $past(wvalid && wready && wlast));

  // R7: response holds until taken
  a_r7_b_hold: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid && $stable(bid) && $stable(bresp));

  // R8: no new write address while a write is open
  a_r8_aw_block: assert property (@(posedge clk) disable iff (rst)
    (wready || bvalid) |-> !awready);

  // R2: data is taken only while a burst is open
  a_r2_wready_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({awready, wready, bvalid}));

endmodule

// File: rtl/axerr_rd_chan.sv
module axerr_rd_chan
  import axerr_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int DATA_W     = 32,
  parameter bit USE_SLVERR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [LEN_W-1:0]  arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast
);

  localparam resp_t ERR_CODE = pick_code(USE_SLVERR);

  rd_state_t       state_q;
  logic [ID_W-1:0] id_q;
  logic            ar_hs, r_hs, cnt_zero;

  assign ar_hs = arvalid && arready;
  assign r_hs  = rvalid && rready;

  axerr_beat_cnt #(.LEN_W(LEN_W)) beat_cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ar_hs),
    .load_val (arlen),
    .dec      (r_hs && !cnt_zero),
    .at_zero  (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RD_ADDR;
      id_q    <= '0;
    end else begin
      case (state_q)
        RD_ADDR: if (ar_hs) begin
          state_q <= RD_BURST;
          id_q    <= arid;
        end
        RD_BURST: if (r_hs && cnt_zero) state_q <= RD_ADDR;
        default: state_q <= RD_ADDR;
      endcase
    end
  end

  assign arready = (state_q == RD_ADDR);
  assign rvalid  = (state_q == RD_BURST);
  assign rid     = id_q;
  assign rdata   = '0;
  assign rresp   = ERR_CODE;
  assign rlast   = rvalid && cnt_zero;

  // R4: after the last beat is taken the burst is over
  a_r4_last_ends: assert property (@(posedge clk) disable iff (rst)
    rvalid && rready && rlast |=> !rvalid && arready);

  // R4: a non-last beat taken leaves the burst open
  a_r4_not_last_continues: assert property (@(posedge clk) disable iff (rst)
    rvalid && rready && !rlast |=> rvalid);

  // R7: beat holds until taken
  a_r7_r_hold: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rlast) && $stable(rid));

  // R8: no new read address during a burst
  a_r8_ar_block: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !arready);

  // R5: zero data on every beat
  a_r5_zero_data: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rdata == '0);

endmodule

// File: rtl/axi_err_slave.sv
module axi_err_slave #(
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int DATA_W     = 32,
  parameter bit USE_SLVERR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ID_W-1:0]   awid,
  input  logic              wvalid,
  output logic              wready,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [LEN_W-1:0]  arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast
);

  axerr_wr_chan #(.ID_W(ID_W), .USE_SLVERR(USE_SLVERR)) wr_i (
    .clk     (clk),
    .rst     (rst),
    .awvalid (awvalid),
    .awready (awready),
    .awid    (awid),
    .wvalid  (wvalid),
    .wready  (wready),
    .wlast   (wlast),
    .bvalid  (bvalid),
    .bready  (bready),
    .bid     (bid),
    .bresp   (bresp)
  );

  axerr_rd_chan #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
                  .USE_SLVERR(USE_SLVERR)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .arvalid (arvalid),
    .arready (arready),
    .arid    (arid),
    .arlen   (arlen),
    .rvalid  (rvalid),
    .rready  (rready),
    .rid     (rid),
    .rdata   (rdata),
    .rresp   (rresp),
    .rlast   (rlast)
  );

  // R6: both channels carry the same error code
  a_r6_same_code: assert property (@(posedge clk) disable iff (rst)
    bvalid && rvalid |-> bresp == rresp);

endmodule

// File: tb/axi_err_slave_tb_top.sv
module axi_err_slave_tb_top;

  localparam int ID_W   = 4;
  localparam int LEN_W  = 8;
  localparam int DATA_W = 32;

  // vector: [14] read, [13:6] length field, [5:2] id, [1:0] stall mode
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 8'd0,  4'h3, 2'd0},
    {1'b1, 8'd15, 4'hA, 2'd0},
    {1'b1, 8'd3,  4'h5, 2'd1},
    {1'b0, 8'd0,  4'h7, 2'd0},
    {1'b0, 8'd15, 4'h9, 2'd0},
    {1'b0, 8'd4,  4'hC, 2'd1},
    {1'b1, 8'd255,4'h1, 2'd0},
    {1'b0, 8'd2,  4'hE, 2'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic awvalid = 0, wvalid = 0, wlast = 0, bready = 0;
  logic arvalid = 0, rready = 0;
  logic [ID_W-1:0]  awid = '0, arid = '0;
  logic [LEN_W-1:0] arlen = '0;

  logic awready, wready, bvalid, arready, rvalid, rlast;
  logic [ID_W-1:0] bid, rid;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata;

  logic awready_s, wready_s, bvalid_s, arready_s, rvalid_s, rlast_s;
  logic [ID_W-1:0] bid_s, rid_s;
  logic [1:0] bresp_s, rresp_s;
  logic [DATA_W-1:0] rdata_s;

  axi_err_slave #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .awvalid(awvalid), .awready(awready), .awid(awid),
    .wvalid(wvalid), .wready(wready), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .arid(arid), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata),
    .rresp(rresp), .rlast(rlast)
  );

  axi_err_slave #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
                  .USE_SLVERR(1'b1)) dut_s (
    .clk(clk), .rst(rst),
    .awvalid(awvalid), .awready(awready_s), .awid(awid),
    .wvalid(wvalid), .wready(wready_s), .wlast(wlast),
    .bvalid(bvalid_s), .bready(bready), .bid(bid_s), .bresp(bresp_s),
    .arvalid(arvalid), .arready(arready_s), .arid(arid), .arlen(arlen),
    .rvalid(rvalid_s), .rready(rready), .rid(rid_s), .rdata(rdata_s),
    .rresp(rresp_s), .rlast(rlast_s)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic check_idle(input string req);
    chk(awready == 1'b1, req, int'(awready), 1);
    chk(arready == 1'b1, req, int'(arready), 1);
    chk(wready == 1'b0, req, int'(wready), 0);
    chk(bvalid == 1'b0, req, int'(bvalid), 0);
    chk(rvalid == 1'b0, req, int'(rvalid), 0);
  endtask

  task automatic do_write(input logic [ID_W-1:0] id, input int nbeats, input int stall);
    @(negedge clk);
    awvalid = 1'b1; awid = id;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0; awid = '0;
    chk(awready == 1'b0, "R8 awready low during write", int'(awready), 0);
    for (int b = 0; b < nbeats; b++) begin
      if (stall == 1 && b > 0) begin
        wvalid = 1'b0;
        @(negedge clk);
        chk(bvalid == 1'b0, "R2 no response during data gap", int'(bvalid), 0);
      end
      wvalid = 1'b1; wlast = (b == nbeats - 1);
      while (!wready) @(negedge clk);
      chk(bvalid == 1'b0, "R2 bvalid before last beat", int'(bvalid), 0);
      @(negedge clk);
    end
    wvalid = 1'b0; wlast = 1'b0;
    chk(bvalid == 1'b1, "R2 bvalid after last beat", int'(bvalid), 1);
    chk(bid == id, "R3 bid echo", int'(bid), int'(id));
    chk(bresp == 2'b11, "R3 R6 bresp decode error", int'(bresp), 3);
    chk(bresp_s == 2'b10, "R6 bresp slave error variant", int'(bresp_s), 2);
    chk(awready == 1'b0, "R8 awready low before response", int'(awready), 0);
    for (int g = 0; g < stall + 1; g++) begin
      @(negedge clk);
      chk(bvalid == 1'b1 && bid == id, "R7 response held", int'(bvalid), 1);
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk(bvalid == 1'b0, "R2 single response", int'(bvalid), 0);
    chk(awready == 1'b1, "R8 awready back", int'(awready), 1);
    repeat (2) @(negedge clk);
    chk(bvalid == 1'b0, "R2 no second response", int'(bvalid), 0);
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input logic [LEN_W-1:0] len,
                         input int stall, input int stop_after);
    int beats;
    int cyc;
    bit done;
    @(negedge clk);
    arvalid = 1'b1; arid = id; arlen = len;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0; arid = '0; arlen = '0;
    beats = 0; cyc = 0; done = 0;
    while (!done) begin
      rready = (stall == 0) || (cyc % 2 == 1);
      chk(rvalid == 1'b1, "R4 beat present", int'(rvalid), 1);
      chk(arready == 1'b0, "R8 arready low during burst", int'(arready), 0);
      if (cyc < 4 || beats == int'(len)) begin
        chk(rid == id, "R5 rid echo", int'(rid), int'(id));
        chk(rresp == 2'b11 && rdata == '0, "R5 R6 rresp and zero data", int'(rresp), 3);
        chk(rresp_s == 2'b10, "R6 rresp slave error variant", int'(rresp_s), 2);
      end
      if (stall != 0 && !rready && cyc > 0)
        chk(rlast == (beats == int'(len)), "R7 rlast held", int'(rlast), int'(beats == int'(len)));
      if (rready) begin
        chk(rlast == (beats == int'(len)), "R4 rlast only on final beat",
            int'(rlast), int'(beats == int'(len)));
        if (rlast) done = 1;
        beats++;
      end
      cyc++;
      @(negedge clk);
      if (stop_after > 0 && beats == stop_after) begin
        rready = 1'b0;
        return;
      end
    end
    rready = 1'b0;
    chk(beats == int'(len) + 1, "R4 beat count", beats, int'(len) + 1);
    chk(rvalid == 1'b0, "R4 burst over", int'(rvalid), 0);
    chk(arready == 1'b1, "R8 arready back", int'(arready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset state");

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][14])
        do_read(VEC[v][5:2], VEC[v][13:6], int'(VEC[v][1:0]), 0);
      else
        do_write(VEC[v][5:2], int'(VEC[v][13:6]) + 1, int'(VEC[v][1:0]));
    end

    // R1: reset in the middle of a read burst
    do_read(4'h6, 8'd5, 0, 2);
    chk(rvalid == 1'b1, "R4 burst still open", int'(rvalid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R1 reset mid burst");

    // R2 R8: write address accepted, data not yet sent; a second address waits
    @(negedge clk);
    awvalid = 1'b1; awid = 4'h2;
    @(negedge clk);
    awid = 4'h4;
    repeat (3) begin
      @(negedge clk);
      chk(awready == 1'b0, "R8 second address held off", int'(awready), 0);
      chk(bvalid == 1'b0, "R2 no response without data", int'(bvalid), 0);
    end
    awvalid = 1'b0;
    wvalid = 1'b1; wlast = 1'b1;
    @(negedge clk);
    wvalid = 1'b0; wlast = 1'b0;
    chk(bvalid == 1'b1 && bid == 4'h2, "R3 first id kept", int'(bid), 2);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;

    finish_run();
  end

endmodule